// File: doc/BRIEF.md
# Circular Event Queue Producer

This block is the producer side of a circular event queue held in ordinary memory. Each accepted enqueue becomes one 32-bit memory write. The write address is the queue base plus four times the producer index. The data word holds the current generation bit in its top bit, with the event payload below it. The index then moves forward by one. When it passes the last slot of the queue it returns to slot zero and the generation bit inverts. A consumer can therefore tell fresh entries from stale ones without sharing a pointer.

The queue capacity comes from two configuration inputs: a cache-line-size select and a size exponent. In line mode the queue is a small multiple of a 128-byte line. In page mode it is a multiple of a 4096-byte page. Each mode has its own upper limit on the exponent. A sticky flipped flag records that the generation has changed. A watch read returns a snapshot of the queue state and clears that flag, so the watcher can see whether a wrap happened since its last look.

Top module: `eqw_top`

## Requirements
- R1: After reset the producer index is 0, the generation bit is 0 and the flipped flag is 0. No write and no watch response is issued until requested.
- R2: With `cfg_line_sel`=1 the queue holds (128 << e)/4 entries, where e is `cfg_size_exp` clamped to at most 4. `cfg_err` is 1 exactly when `cfg_size_exp` exceeds 4.
- R3: With `cfg_line_sel`=0 the queue holds (4096 << e)/4 entries, where e is `cfg_size_exp` clamped to at most 12. `cfg_err` is 1 exactly when `cfg_size_exp` exceeds 12.
- R4: In the cycle after an enqueue, `mem_wr_en` is 1 and `mem_wr_addr` equals `cfg_base` + 4 × index. `mem_wr_data` holds the generation bit in bit 31 and the payload in bits 30:0. `mem_wr_en` is 0 after a cycle without an enqueue.
- R5: Each enqueue advances the index by one. A cycle without an enqueue leaves the index and the generation bit unchanged.
- R6: An enqueue at the last slot moves the index to 0 and inverts the generation bit. Later entries are written with the new generation.
- R7: A wrap sets the flipped flag to 1. The flag stays at 1 until a watch read.
- R8: In the cycle after a watch read, `watch_vld` is 1 and the watch outputs carry the index, generation and flipped flag from before that cycle. The flipped flag is then 0 unless R9 applies.
- R9: When a watch read and a wrapping enqueue fall in the same cycle, the read returns the flag's earlier value and the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_line_sel | input | 1 | 1: 128-byte line base size, 0: 4096-byte page base size |
| cfg_size_exp | input | 4 | Size exponent |
| cfg_base | input | 48 | Byte address of queue slot 0 |
| cfg_err | output | 1 | Exponent above the limit of the selected mode |
| enq_valid | input | 1 | Append one event this cycle |
| enq_payload | input | 31 | Event payload |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 48 | Memory write byte address |
| mem_wr_data | output | 32 | Generation bit and payload |
| watch_rd | input | 1 | Watch read of the queue state |
| watch_vld | output | 1 | Watch response valid |
| watch_idx | output | 22 | Index snapshot |
| watch_gen | output | 1 | Generation snapshot |
| watch_flipped | output | 1 | Flipped flag snapshot |

## Verification
Two operations can land in the same cycle: an enqueue that wraps, which sets the flipped flag, and a watch read, which clears it. The bench provokes this with a directed case. It fills the smallest queue up to its last slot and then issues a watch read together with the wrapping enqueue. It expects the snapshot to show the old flag value of 0 and the next watch read to show 1. Random traffic that mixes the two operations is also checked every cycle against a bench model, which covers the collisions that occur by chance.

// File: rtl/eqw_pkg.sv
package eqw_pkg;
   typedef enum logic {
      SZ_PAGE = 1'b0,
      SZ_LINE = 1'b1
   } sz_mode_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/eqw_size_decode.sv
module eqw_size_decode #(
   parameter int EXP_W        = 4,
   parameter int IDX_W        = 22,
   parameter int ENTRY_LG     = 2,
   parameter int LINE_BASE_LG = 7,
   parameter int LINE_EXP_MAX = 4,
   parameter int PAGE_BASE_LG = 12,
   parameter int PAGE_EXP_MAX = 12
) (
   input  logic             line_sel,
   input  logic [EXP_W-1:0] size_exp,
   output logic [IDX_W-1:0] last_idx,
   output logic             err
);
   localparam int LG_W = $clog2(IDX_W + 1) + 1;

   logic [1:0]      lane_err;
   logic [LG_W-1:0] lane_lg [2];

   for (genvar l = 0; l < 2; l++) begin : g_lane
      localparam int BASE = (l == int'(eqw_pkg::SZ_LINE)) ? LINE_BASE_LG : PAGE_BASE_LG;
      localparam int EMAX = (l == int'(eqw_pkg::SZ_LINE)) ? LINE_EXP_MAX : PAGE_EXP_MAX;
      logic [EXP_W-1:0] eff;
      always_comb begin
         lane_err[l] = (size_exp > EXP_W'(EMAX));
         eff         = lane_err[l] ? EXP_W'(EMAX) : size_exp;
         lane_lg[l]  = LG_W'(BASE - ENTRY_LG) + LG_W'(eff);
      end
   end

   logic [LG_W-1:0] sel_lg;
   logic [IDX_W:0]  span;

   always_comb begin
      sel_lg   = lane_lg[line_sel];
      err      = lane_err[line_sel];
      span     = (IDX_W+1)'(1) << sel_lg;
      last_idx = IDX_W'(span - (IDX_W+1)'(1));
   end
endmodule

// File: rtl/eqw_prod_ptr.sv
module eqw_prod_ptr #(
   parameter int IDX_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enq,
   input  logic             watch,
   input  logic [IDX_W-1:0] last_idx,
   output logic [IDX_W-1:0] idx_q,
   output logic             gen_q,
   output logic             flip_q,
   output logic             wrap
);
   always_comb wrap = enq && (idx_q >= last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         gen_q  <= 1'b0;
         flip_q <= 1'b0;
      end else begin
         if (enq) begin
            idx_q <= wrap ? '0 : idx_q + IDX_W'(1);
            if (wrap) gen_q <= ~gen_q;
         end
         // the wrap wins over the watch clear
         if (wrap)       flip_q <= 1'b1;
         else if (watch) flip_q <= 1'b0;
      end
   end
endmodule

// File: rtl/eqw_write_fmt.sv
module eqw_write_fmt #(
   parameter int ADDR_W   = 48,
   parameter int IDX_W    = 22,
   parameter int PAY_W    = 31,
   parameter int ENTRY_LG = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq,
   input  logic [PAY_W-1:0]  payload,
   input  logic [IDX_W-1:0]  idx,
   input  logic              gen,
   input  logic [ADDR_W-1:0] base,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [PAY_W:0]    wr_data
);
   logic [ADDR_W-1:0] slot_ofs;
   always_comb slot_ofs = ADDR_W'(idx) << ENTRY_LG;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= enq;
         if (enq) begin
            wr_addr <= base + slot_ofs;
            wr_data <= {gen, payload};
         end
      end
   end
endmodule

// File: rtl/eqw_watch_port.sv
module eqw_watch_port #(
   parameter int IDX_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             watch,
   input  logic [IDX_W-1:0] idx,
   input  logic             gen,
   input  logic             flip,
   output logic             vld,
   output logic [IDX_W-1:0] snap_idx,
   output logic             snap_gen,
   output logic             snap_flip
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld       <= 1'b0;
         snap_idx  <= '0;
         snap_gen  <= 1'b0;
         snap_flip <= 1'b0;
      end else begin
         vld <= watch;
         if (watch) begin
            snap_idx  <= idx;
            snap_gen  <= gen;
            snap_flip <= flip;
         end
      end
   end
endmodule

// File: rtl/eqw_top.sv
module eqw_top #(
   parameter int ADDR_W       = 48,
   parameter int PAY_W        = 31,
   parameter int EXP_W        = 4,
   parameter int ENTRY_LG     = 2,
   parameter int LINE_BASE_LG = 7,
   parameter int LINE_EXP_MAX = 4,
   parameter int PAGE_BASE_LG = 12,
   parameter int PAGE_EXP_MAX = 12,
   localparam int LG_MAX      = eqw_pkg::max2(LINE_BASE_LG + LINE_EXP_MAX,
                                              PAGE_BASE_LG + PAGE_EXP_MAX),
   localparam int IDX_W       = LG_MAX - ENTRY_LG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_line_sel,
   input  logic [EXP_W-1:0]  cfg_size_exp,
   input  logic [ADDR_W-1:0] cfg_base,
   output logic              cfg_err,
   input  logic              enq_valid,
   input  logic [PAY_W-1:0]  enq_payload,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [PAY_W:0]    mem_wr_data,
   input  logic              watch_rd,
   output logic              watch_vld,
   output logic [IDX_W-1:0]  watch_idx,
   output logic              watch_gen,
   output logic              watch_flipped
);
   initial begin
      assert (LINE_BASE_LG > ENTRY_LG && PAGE_BASE_LG > ENTRY_LG)
         else $fatal(1, "base size smaller than one entry");
      assert ((1 << EXP_W) > eqw_pkg::max2(LINE_EXP_MAX, PAGE_EXP_MAX))
         else $fatal(1, "exponent field too narrow");
      assert (ADDR_W > LG_MAX)
         else $fatal(1, "address too narrow for largest queue");
   end

   logic [IDX_W-1:0] last_idx;
   logic [IDX_W-1:0] idx_q;
   logic             gen_q;
   logic             flip_q;
   logic             wrap;

   eqw_size_decode #(
      .EXP_W(EXP_W), .IDX_W(IDX_W), .ENTRY_LG(ENTRY_LG),
      .LINE_BASE_LG(LINE_BASE_LG), .LINE_EXP_MAX(LINE_EXP_MAX),
      .PAGE_BASE_LG(PAGE_BASE_LG), .PAGE_EXP_MAX(PAGE_EXP_MAX)
   ) u_size (
      .line_sel(cfg_line_sel), .size_exp(cfg_size_exp),
      .last_idx(last_idx), .err(cfg_err)
   );

   eqw_prod_ptr #(.IDX_W(IDX_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .enq(enq_valid), .watch(watch_rd),
      .last_idx(last_idx), .idx_q(idx_q), .gen_q(gen_q),
      .flip_q(flip_q), .wrap(wrap)
   );

   eqw_write_fmt #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PAY_W(PAY_W), .ENTRY_LG(ENTRY_LG)
   ) u_wr (
      .clk(clk), .rst_n(rst_n), .enq(enq_valid), .payload(enq_payload),
      .idx(idx_q), .gen(gen_q), .base(cfg_base),
      .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data)
   );

   eqw_watch_port #(.IDX_W(IDX_W)) u_watch (
      .clk(clk), .rst_n(rst_n), .watch(watch_rd),
      .idx(idx_q), .gen(gen_q), .flip(flip_q),
      .vld(watch_vld), .snap_idx(watch_idx), .snap_gen(watch_gen),
      .snap_flip(watch_flipped)
   );
endmodule

// File: rtl/eqw_check.sv
module eqw_check #(
   parameter int IDX_W        = 22,
   parameter int EXP_W        = 4,
   parameter int LINE_EXP_MAX = 4,
   parameter int PAGE_EXP_MAX = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_line_sel,
   input logic [EXP_W-1:0] cfg_size_exp,
   input logic             cfg_err,
   input logic             enq_valid,
   input logic             watch_rd,
   input logic             mem_wr_en,
   input logic             watch_vld,
   input logic             watch_flipped,
   input logic [IDX_W-1:0] idx_q,
   input logic             gen_q,
   input logic             flip_q,
   input logic [IDX_W-1:0] last_idx
);
   logic at_end;
   always_comb at_end = enq_valid && (idx_q >= last_idx);

   a_r2_line_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_line_sel && cfg_size_exp > EXP_W'(LINE_EXP_MAX)) |-> cfg_err);
   a_r3_page_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_line_sel && cfg_size_exp <= EXP_W'(PAGE_EXP_MAX)) |-> !cfg_err);
   a_r4_write_after_enq: assert property (@(posedge clk) disable iff (!rst_n)
      enq_valid |=> mem_wr_en);
   a_r4_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !enq_valid |=> !mem_wr_en);
   a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !enq_valid |=> ($stable(idx_q) && $stable(gen_q)));
   a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      at_end |=> (idx_q == '0 && gen_q != $past(gen_q)));
   a_r7_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      at_end |=> flip_q);
   a_r8_watch_answers: assert property (@(posedge clk) disable iff (!rst_n)
      watch_rd |=> watch_vld);
   a_r8_watch_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (watch_rd && !at_end) |=> !flip_q);
   a_r9_collision: assert property (@(posedge clk) disable iff (!rst_n)
      (watch_rd && at_end && !flip_q) |=> (!watch_flipped && flip_q));
endmodule

bind eqw_top eqw_check #(
   .IDX_W(IDX_W), .EXP_W(EXP_W),
   .LINE_EXP_MAX(LINE_EXP_MAX), .PAGE_EXP_MAX(PAGE_EXP_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_line_sel(cfg_line_sel),
   .cfg_size_exp(cfg_size_exp), .cfg_err(cfg_err),
   .enq_valid(enq_valid), .watch_rd(watch_rd), .mem_wr_en(mem_wr_en),
   .watch_vld(watch_vld), .watch_flipped(watch_flipped),
   .idx_q(idx_q), .gen_q(gen_q), .flip_q(flip_q), .last_idx(last_idx)
);

// File: tb/eqw_top_tb.sv
`timescale 1ns/1ps
module eqw_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_line_sel = 1'b1;
   logic [3:0]  cfg_size_exp = '0;
   logic [47:0] cfg_base = 48'h0000_1000;
   logic        cfg_err;
   logic        enq_valid = 1'b0;
   logic [30:0] enq_payload = '0;
   logic        mem_wr_en;
   logic [47:0] mem_wr_addr;
   logic [31:0] mem_wr_data;
   logic        watch_rd = 1'b0;
   logic        watch_vld;
   logic [21:0] watch_idx;
   logic        watch_gen;
   logic        watch_flipped;

   always #2 clk = ~clk;

   eqw_top u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_line_sel(cfg_line_sel),
      .cfg_size_exp(cfg_size_exp), .cfg_base(cfg_base), .cfg_err(cfg_err),
      .enq_valid(enq_valid), .enq_payload(enq_payload),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .watch_rd(watch_rd), .watch_vld(watch_vld), .watch_idx(watch_idx),
      .watch_gen(watch_gen), .watch_flipped(watch_flipped)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   int m_idx;
   bit m_gen;
   bit m_flip;
   int m_last;
   logic [31:0] mem [4096];

   function automatic int entries_of(input bit sel, input int e);
      if (sel) return 32 << ((e > 4) ? 4 : e);
      return 1024 << ((e > 12) ? 12 : e);
   endfunction

   function automatic bit err_of(input bit sel, input int e);
      return sel ? (e > 4) : (e > 12);
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input bit sel, input int e);
      @(negedge clk);
      rst_n = 1'b0; enq_valid = 1'b0; watch_rd = 1'b0;
      cfg_line_sel = sel; cfg_size_exp = 4'(e);
      repeat (2) @(negedge clk);
      chk(mem_wr_en == 1'b0, "R1 no write in reset", 64'(mem_wr_en), 0);
      chk(watch_vld == 1'b0, "R1 no watch in reset", 64'(watch_vld), 0);
      chk(cfg_err == err_of(sel, e), sel ? "R2 err flag" : "R3 err flag",
          64'(cfg_err), 64'(err_of(sel, e)));
      rst_n = 1'b1;
      m_idx = 0; m_gen = 1'b0; m_flip = 1'b0;
      m_last = entries_of(sel, e) - 1;
   endtask

   task automatic step(input bit e, input bit w);
      logic [30:0] p;
      bit wrapped;
      p = 31'($urandom);
      enq_valid = e; enq_payload = p; watch_rd = w;
      @(posedge clk);
      @(negedge clk);
      wrapped = e && (m_idx >= m_last);
      chk(mem_wr_en == e, "R4 write strobe", 64'(mem_wr_en), 64'(e));
      if (e) begin
         chk(mem_wr_addr == cfg_base + 48'(m_idx * 4), "R4 address",
             64'(mem_wr_addr), 64'(cfg_base + 48'(m_idx * 4)));
         chk(mem_wr_data == {m_gen, p}, "R4 R6 data word",
             64'(mem_wr_data), 64'({m_gen, p}));
         mem[((mem_wr_addr - cfg_base) >> 2) % 4096] = mem_wr_data;
      end
      chk(watch_vld == w, "R8 watch valid", 64'(watch_vld), 64'(w));
      if (w) begin
         chk(watch_idx == 22'(m_idx), "R5 R2 R3 index", 64'(watch_idx), 64'(m_idx));
         chk(watch_gen == m_gen, "R6 generation", 64'(watch_gen), 64'(m_gen));
         chk(watch_flipped == m_flip, wrapped ? "R9 old flag" : "R7 R8 flag",
             64'(watch_flipped), 64'(m_flip));
      end
      if (e) begin
         if (wrapped) begin
            m_idx = 0; m_gen = ~m_gen; m_flip = 1'b1;
         end else begin
            m_idx++;
         end
      end
      if (w && !wrapped) m_flip = 1'b0;
      enq_valid = 1'b0; watch_rd = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));

      // R1: reset state
      do_reset(1'b1, 0);
      step(1'b0, 1'b1);

      // R9: collision of wrapping enqueue and watch read, smallest queue
      for (int i = 0; i < 31; i++) step(1'b1, 1'b0);
      step(1'b1, 1'b1);
      chk(m_flip == 1'b1, "R9 model flag", 64'(m_flip), 1);
      step(1'b0, 1'b1);
      step(1'b0, 1'b1);
      step(1'b1, 1'b0);
      chk(mem[0][31] == 1'b1, "R6 new generation in memory", 64'(mem[0][31]), 1);
      // R7: flag sticks across idle and enqueue cycles until read
      for (int i = 0; i < 32; i++) step(1'b1, 1'b0);
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      step(1'b0, 1'b1);

      // R2 / R3: sizes per mode, random traffic through two wraps
      for (int c = 0; c < 6; c++) begin
         bit sel;
         int e;
         case (c)
            0: begin sel = 1'b1; e = 0; end
            1: begin sel = 1'b1; e = 2; end
            2: begin sel = 1'b1; e = 4; end
            3: begin sel = 1'b1; e = 9; end
            4: begin sel = 1'b0; e = 0; end
            default: begin sel = 1'b0; e = 1; end
         endcase
         cfg_base = {16'h0, 32'($urandom) & 32'hFFFF_F000};
         do_reset(sel, e);
         for (int i = 0; i < 3 * entries_of(sel, e) + 40; i++)
            step(($urandom % 4) != 0, ($urandom % 16) == 0);
         step(1'b0, 1'b1);
      end

      // R3: page-mode limit and clamp flag, short traffic only
      do_reset(1'b0, 12);
      for (int i = 0; i < 20; i++) step(1'b1, ($urandom % 4) == 0);
      do_reset(1'b0, 13);
      for (int i = 0; i < 20; i++) step(1'b1, ($urandom % 4) == 0);
      do_reset(1'b1, 5);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule